// File: doc/BRIEF.md
# Modular-Exponentiation Accelerator Load and Control Front End

This block sits in front of a modular-exponentiation core. A host programs it through a small 32-bit register window. The block then fetches an operand image from system memory with a simple read-request master and stores it in a local scratch SRAM. The image interleaves three kinds of data in a 12-dword period: four exponent dwords, then four modulus dwords, then four data dwords. The host can later read any operand dword by naming its region and its logical index, and the block turns that pair into the physical scratch address.

The block passes the exponent and modulus bit lengths to the core and starts the core once the fetch has finished. It records completion in a status register that the host clears by writing ones, and it drives an interrupt through a mask. A command bit decides who owns the scratch SRAM: the engine or the host bus. The arithmetic core is not part of this block. A stub stands in for it and reports done a fixed number of cycles after it starts.

Top module: `pka_dma_front`

## Requirements
- R1: After synchronous reset, `busy` and `irq` are low, and the status, command and mask registers read as zero.
- R2: A fetch reads floor(length/4) dwords, capped at the image size. The reads go to consecutive addresses base, base+4, and so on. `mem_addr` holds steady while `mem_req` is high and `mem_ack` is low.
- R3: Fetched dword k is stored at scratch dword k. A host read of region r (0 = exponent, 1 = modulus, 2 = data) at logical index i returns scratch dword (i/4)*12 + 4*r + (i mod 4). Region 3 reads as zero.
- R4: Trigger bit 1 (register 0x000) starts a fetch only when command bits [5:4] equal 2'b11. Otherwise the fetch request is ignored and `mem_req` stays low.
- R5: Trigger bit 0 starts the core. If bit 1 also starts a fetch, the core starts only after the last dword has arrived. If the core starts from a trigger alone, status bit 1 is set DONE_DELAY cycles after the trigger write.
- R6: Status (0x3FC) bit 1 is core completion and bit 0 is the trigger-while-busy error. Writing a 1 to a status bit clears it. `irq` is high exactly when a set status bit has its mask bit (0x3F8) set.
- R7: A nonzero trigger write while `busy` is high is ignored: the fetch address keeps its value and no core run follows. The write also sets status bit 0.
- R8: Writing zero to the trigger register stops the fetch and the core. `busy` and `mem_req` are low in the next cycle.
- R9: While command bit 8 is set, a host SRAM read returns data with `sram_rvalid` one cycle later. While bit 8 is clear, the read still returns `sram_rvalid` one cycle later, but the data is zero.
- R10: Dwords fetched while command bit 8 is set are dropped, and the scratch contents stay unchanged.
- R11: `exp_bits` shows key-length register (0x058) bits [31:16], and `mod_bits` shows bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Fetch read request |
| mem_addr | output | 32 | Fetch byte address |
| mem_ack | input | 1 | Request accepted, mem_rdata valid |
| mem_rdata | input | 32 | Fetched dword |
| sram_rd | input | 1 | Host scratch read strobe |
| sram_region | input | 2 | Region of host read |
| sram_idx | input | IDX_W | Logical dword index in region |
| sram_rdata | output | 32 | Host read data |
| sram_rvalid | output | 1 | Host read data valid |
| exp_bits | output | 16 | Exponent bit length to core |
| mod_bits | output | 16 | Modulus bit length to core |
| busy | output | 1 | Fetch, core or pending core start active |
| irq | output | 1 | Masked completion/error interrupt |

## Verification
The first sign of a wrong fetch counter is a `mem_addr` off the expected sequence, and it shows up at the very next acknowledge. A wrong placement only shows up later, when the host reads the scratch SRAM back, so each fetch run is followed by a full region-by-region readback. A wrong start or stop state shows up as a shifted `irq` rising edge, as a missing completion bit, or as `busy` staying high one cycle after a stop. The bench measures all three to the exact cycle.

// File: rtl/pka_pkg.sv
// Package: register offsets and scratch address mapping shared by the front end.
// Assumes byte offsets on a 12-bit register address.
package pka_pkg;
    localparam logic [11:0] OFF_TRIG = 12'h000;
    localparam logic [11:0] OFF_CMD  = 12'h048;
    localparam logic [11:0] OFF_BASE = 12'h04C;
    localparam logic [11:0] OFF_LEN  = 12'h050;
    localparam logic [11:0] OFF_KEY  = 12'h058;
    localparam logic [11:0] OFF_MASK = 12'h3F8;
    localparam logic [11:0] OFF_STAT = 12'h3FC;

    // Physical scratch dword of logical index idx in a region (0 exp, 1 mod, 2 data)
    function automatic logic [31:0] phys_dword(input logic [1:0] region, input logic [31:0] idx);
        return ((idx >> 2) * 32'd12) + ({30'd0, region} << 2) + {30'd0, idx[1:0]};
    endfunction
endpackage

// File: rtl/pka_fetch.sv
// Fetch master: issues sequential dword reads from a latched base and emits
// one scratch write per acknowledged read. Assumes data arrives with mem_ack.
module pka_fetch #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [31:0]   base,
    input  logic [CW-1:0] ndw,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          mem_req,
    output logic [31:0]   mem_addr,
    output logic          wr_en,
    output logic [CW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    output logic          busy,
    output logic          done
);
    logic          busy_q, done_q;
    logic [CW-1:0] cnt_q, last_q;
    logic [31:0]   base_q;

    // Sequence the dword counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            last_q <= '0;
            base_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
            end else if (start) begin
                cnt_q  <= '0;
                base_q <= base;
                last_q <= ndw - CW'(1);
                if (ndw == '0) done_q <= 1'b1;
                else           busy_q <= 1'b1;
            end else if (busy_q && mem_ack) begin
                cnt_q <= cnt_q + CW'(1);
                if (cnt_q == last_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Drive request, address and the scratch write
    always_comb begin
        mem_req  = busy_q;
        mem_addr = base_q + (32'(cnt_q) << 2);
        wr_en    = busy_q && mem_ack && !abort;
        wr_addr  = cnt_q;
        wr_data  = mem_rdata;
        busy     = busy_q;
        done     = done_q;
    end
endmodule

// File: rtl/pka_scratch.sv
// Scratch SRAM with ownership: engine writes only when the host does not own it;
// host reads by (region, index) with one cycle latency. Memory is not reset.
module pka_scratch #(
    parameter int DEPTH = 1536,
    parameter int AW    = 11,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_own,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_region,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    output logic             rd_valid
);
    logic [31:0] mem [DEPTH];
    logic [31:0] phys;
    logic        hit;

    // Translate the host logical address and qualify it
    always_comb begin
        phys = pka_pkg::phys_dword(rd_region, 32'(rd_idx));
        hit  = rd_en && host_own && (rd_region != 2'd3) && (phys < 32'(DEPTH));
    end

    // Engine write port, blocked under host ownership
    always_ff @(posedge clk) begin
        if (wr_en && !host_own) mem[wr_addr] <= wr_data;
    end

    // Host read port with registered data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= hit ? mem[phys[AW-1:0]] : 32'd0;
        end
    end
endmodule

// File: rtl/pka_expo_stub.sv
// Stand-in for the exponentiation core: busy for DELAY cycles after start,
// then a one-cycle done. Assumes DELAY >= 1.
module pka_expo_stub #(
    parameter int DELAY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CNTW = $clog2(DELAY + 1);
    logic            busy_q;
    logic [CNTW-1:0] cnt_q;

    // Count down the run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNTW'(DELAY - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - CNTW'(1);
        end
    end

    // Completion flag on the last counted cycle
    always_comb begin
        busy = busy_q;
        done = busy_q && (cnt_q == '0) && !abort;
    end
endmodule

// File: rtl/pka_dma_front.sv
// Front end top: register window, start/stop sequencing, status and interrupt.
// Assumes single-cycle register writes and combinational register reads.
module pka_dma_front #(
    parameter int IMG_DWORDS = 1536,
    parameter int DONE_DELAY = 20,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [11:0]      reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             sram_rd,
    input  logic [1:0]       sram_region,
    input  logic [IDX_W-1:0] sram_idx,
    output logic [31:0]      sram_rdata,
    output logic             sram_rvalid,
    output logic [15:0]      exp_bits,
    output logic [15:0]      mod_bits,
    output logic             busy,
    output logic             irq
);
    import pka_pkg::*;
    localparam int AW = $clog2(IMG_DWORDS);
    localparam int CW = AW + 1;

    logic [31:0]   cmd_q, base_q, len_q, key_q, mask_q;
    logic [1:0]    stat_q, stat_d;
    logic          arm_q;
    logic          trig_wr, stop, go, fetch_go, core_go, eng_busy, mode_ok;
    logic          fetch_busy, fetch_done, core_busy, core_done;
    logic          wr_en;
    logic [CW-1:0] wr_addr, ndw;
    logic [31:0]   wr_data;
    logic [29:0]   len_dw;

    // Decode trigger writes and derive start/stop strobes
    always_comb begin
        mode_ok  = (cmd_q[5:4] == 2'b11);
        eng_busy = fetch_busy | core_busy | arm_q;
        trig_wr  = reg_wr && (reg_addr == OFF_TRIG);
        stop     = trig_wr && (reg_wdata[1:0] == 2'b00);
        go       = trig_wr && (reg_wdata[1:0] != 2'b00) && !eng_busy;
        fetch_go = go && reg_wdata[1] && mode_ok;
        core_go  = !stop && ((go && reg_wdata[0] && !fetch_go) || (arm_q && fetch_done));
        len_dw   = len_q[31:2];
        ndw      = (len_dw > 30'(IMG_DWORDS)) ? CW'(IMG_DWORDS) : len_dw[CW-1:0];
    end

    // Next status: write-one-to-clear, with set events taking priority
    always_comb begin
        stat_d = stat_q;
        if (reg_wr && reg_addr == OFF_STAT) stat_d = stat_d & ~reg_wdata[1:0];
        if (trig_wr && reg_wdata[1:0] != 2'b00 && eng_busy) stat_d[0] = 1'b1;
        if (core_done) stat_d[1] = 1'b1;
    end

    // Register file, pending-core flag and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            base_q <= '0;
            len_q  <= '0;
            key_q  <= '0;
            mask_q <= '0;
            stat_q <= '0;
            arm_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            if (reg_wr) begin
                case (reg_addr)
                    OFF_CMD:  cmd_q  <= reg_wdata;
                    OFF_BASE: base_q <= reg_wdata;
                    OFF_LEN:  len_q  <= reg_wdata;
                    OFF_KEY:  key_q  <= reg_wdata;
                    OFF_MASK: mask_q <= reg_wdata;
                    default:  ;
                endcase
            end
            if (stop)                      arm_q <= 1'b0;
            else if (fetch_go)             arm_q <= reg_wdata[0];
            else if (arm_q && fetch_done)  arm_q <= 1'b0;
        end
    end

    // Register read multiplexer
    always_comb begin
        case (reg_addr)
            OFF_TRIG: reg_rdata = {30'd0, fetch_busy, core_busy | arm_q};
            OFF_CMD:  reg_rdata = cmd_q;
            OFF_BASE: reg_rdata = base_q;
            OFF_LEN:  reg_rdata = len_q;
            OFF_KEY:  reg_rdata = key_q;
            OFF_MASK: reg_rdata = mask_q;
            OFF_STAT: reg_rdata = {30'd0, stat_q};
            default:  reg_rdata = 32'd0;
        endcase
    end

    // Outputs to the core and the host
    always_comb begin
        exp_bits = key_q[31:16];
        mod_bits = key_q[15:0];
        busy     = eng_busy;
        irq      = |(stat_q & mask_q[1:0]);
    end

    pka_fetch #(.CW(CW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(fetch_go), .abort(stop),
        .base(base_q), .ndw(ndw), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(fetch_busy), .done(fetch_done)
    );

    pka_scratch #(.DEPTH(IMG_DWORDS), .AW(AW), .IDX_W(IDX_W)) u_scratch (
        .clk(clk), .rst_n(rst_n), .host_own(cmd_q[8]), .wr_en(wr_en),
        .wr_addr(wr_addr[AW-1:0]), .wr_data(wr_data), .rd_en(sram_rd),
        .rd_region(sram_region), .rd_idx(sram_idx), .rd_data(sram_rdata),
        .rd_valid(sram_rvalid)
    );

    pka_expo_stub #(.DELAY(DONE_DELAY)) u_core (
        .clk(clk), .rst_n(rst_n), .start(core_go), .abort(stop),
        .busy(core_busy), .done(core_done)
    );
endmodule

// File: rtl/pka_dma_front_chk.sv
// Checker for pka_dma_front: temporal rules on fetch, status and start/stop.
module pka_dma_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [11:0] reg_addr,
    input logic [31:0] reg_wdata,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        sram_rd,
    input logic        sram_rvalid,
    input logic        busy,
    input logic [1:0]  stat_q,
    input logic        core_go,
    input logic        fetch_busy
);
    // R2
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !(reg_wr && reg_addr == 12'h000)) |=> (mem_req && $stable(mem_addr)));
    // R9
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_rvalid |-> $past(sram_rd));
    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[1]) |-> $past(reg_wr && reg_addr == 12'h3FC && reg_wdata[1]));
    // R7
    busy_trig_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == 12'h000 && reg_wdata[1:0] != 2'b00) |=> stat_q[0]);
    // R5
    core_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_go |-> !fetch_busy);
    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 12'h000 && reg_wdata[1:0] == 2'b00) |=> (!busy && !mem_req));
endmodule

bind pka_dma_front pka_dma_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .sram_rd(sram_rd),
    .sram_rvalid(sram_rvalid), .busy(busy), .stat_q(stat_q), .core_go(core_go),
    .fetch_busy(fetch_busy)
);

// File: tb/tb_pka_dma_front.sv
// Bench: directed corner cases plus seeded random fetch runs, checked against a scratch model.
module tb_pka_dma_front;
    localparam int IMG = 1536;
    localparam int DLY = 20;
    localparam int IW  = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req;
    logic [31:0]   mem_addr;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          sram_rd = 1'b0;
    logic [1:0]    sram_region = '0;
    logic [IW-1:0] sram_idx = '0;
    logic [31:0]   sram_rdata;
    logic          sram_rvalid;
    logic [15:0]   exp_bits, mod_bits;
    logic          busy, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ack_cnt = 0;
    logic [31:0] exp_base = '0;
    logic [31:0] salt = '0;
    bit stall = 1'b0;
    bit model_wr = 1'b1;
    logic [31:0] model [IMG];
    bit mv [IMG];

    pka_dma_front #(.IMG_DWORDS(IMG), .DONE_DELAY(DLY), .IDX_W(IW)) dut (.*);

    always #2 clk = ~clk;  // 250 MHz

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic int phys(input int r, input int i);
        return (i / 4) * 12 + r * 4 + (i % 4);
    endfunction

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Memory responder: random acks, address sequence check (R2), scratch model update
    always @(negedge clk) begin
        mem_ack = mem_req && !stall && ($urandom % 3 != 0);
        if (mem_ack) begin
            chk(mem_addr == exp_base + 32'(ack_cnt) * 4, "R2 fetch address", mem_addr, exp_base + 32'(ack_cnt) * 4);
            mem_rdata = mem_addr ^ salt;
            if (model_wr && ack_cnt < IMG) begin
                model[ack_cnt] = mem_rdata;
                mv[ack_cnt] = 1'b1;
            end
            ack_cnt++;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic sread(input int r, input int i, output logic [31:0] v, output logic vld);
        @(negedge clk);
        sram_rd = 1'b1; sram_region = 2'(r); sram_idx = IW'(i);
        @(negedge clk);
        sram_rd = 1'b0;
        v = sram_rdata; vld = sram_rvalid;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
    endtask

    // One fetch run; host_own drops the writes, with_core also starts the core
    task automatic run_fetch(input int ndw, input int extra, input bit host_own, input bit with_core);
        logic [31:0] v;
        wr(12'h048, host_own ? 32'h130 : 32'h30);
        exp_base = $urandom & 32'h0FFF_FFF0;
        salt = $urandom;
        model_wr = !host_own;
        ack_cnt = 0;
        wr(12'h04C, exp_base);
        wr(12'h050, 32'(ndw * 4 + extra));
        wr(12'h000, with_core ? 32'h3 : 32'h2);
        wait_idle();
        chk(ack_cnt == ndw, "R2 dword count", 32'(ack_cnt), 32'(ndw));
        chk(busy == 1'b0, "R5 idle after run", 32'(busy), 0);
        if (with_core) begin
            rd(12'h3FC, v);
            chk(v[1] == 1'b1, "R5 done after fetch", v, 32'h2);
            wr(12'h3FC, v);
        end
    endtask

    // Host readback of all modelled dwords by region (R3, R9)
    task automatic readback();
        logic [31:0] v;
        logic vld;
        wr(12'h048, 32'h100);
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 128; i++) begin
                if (mv[phys(r, i)]) begin
                    sread(r, i, v, vld);
                    chk(vld && v == model[phys(r, i)], "R3 region readback", v, model[phys(r, i)]);
                end
            end
        end
    endtask

    initial begin
        logic [31:0] v, a0;
        logic vld;
        int n;
        void'($urandom(32'd2024));
        for (int k = 0; k < IMG; k++) mv[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !irq, "R1 busy/irq", {30'd0, busy, irq}, 0);
        rd(12'h3FC, v); chk(v == 0, "R1 status", v, 0);
        rd(12'h048, v); chk(v == 0, "R1 command", v, 0);
        rd(12'h3F8, v); chk(v == 0, "R1 mask", v, 0);

        // R11 key lengths
        v = $urandom;
        wr(12'h058, v);
        chk(exp_bits == v[31:16], "R11 exp_bits", 32'(exp_bits), 32'(v[31:16]));
        chk(mod_bits == v[15:0], "R11 mod_bits", 32'(mod_bits), 32'(v[15:0]));

        // R5 core-only latency, R6 mask and clear
        wr(12'h3F8, 32'h2);
        wr(12'h000, 32'h1);
        n = 1;
        while (!irq && n < 1000) begin @(negedge clk); n++; end
        chk(n == DLY + 1, "R5 core latency", 32'(n), 32'(DLY + 1));
        rd(12'h3FC, v); chk(v == 32'h2, "R6 status done", v, 32'h2);
        wr(12'h3F8, 32'h0);
        chk(irq == 1'b0, "R6 mask off", 32'(irq), 0);
        wr(12'h3F8, 32'h2);
        chk(irq == 1'b1, "R6 mask on", 32'(irq), 1);
        wr(12'h3FC, 32'h2);
        chk(irq == 1'b0, "R6 w1c irq", 32'(irq), 0);
        rd(12'h3FC, v); chk(v == 0, "R6 w1c status", v, 0);

        // R4 fetch ignored without load mode
        wr(12'h048, 32'h0);
        wr(12'h000, 32'h2);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!mem_req && !busy, "R4 no fetch", {30'd0, mem_req, busy}, 0);
        end

        // R9 engine-owned host read gives zero
        wr(12'h048, 32'h30);
        sread(2, 0, v, vld);
        chk(vld && v == 0, "R9 engine owned read", v, 0);

        // Directed three-period fetch with core, then random runs
        run_fetch(36, 0, 1'b0, 1'b1);
        readback();
        for (int t = 0; t < 5; t++) begin
            run_fetch(1 + int'($urandom % 60), int'($urandom % 4), 1'b0, ($urandom % 2) == 1);
            readback();
        end
        // R3 region 3 reads as zero
        sread(3, 0, v, vld);
        chk(vld && v == 0, "R3 region 3", v, 0);

        // R10 fetch under host ownership is dropped
        run_fetch(24, 0, 1'b1, 1'b0);
        readback();

        // R7 trigger while busy, R8 stop
        stall = 1'b1;
        ack_cnt = 0;
        wr(12'h048, 32'h30);
        wr(12'h050, 32'd16);
        exp_base = 32'h0;
        wr(12'h04C, 32'h0);
        wr(12'h000, 32'h2);
        a0 = mem_addr;
        chk(busy && mem_req, "R7 fetch stalled busy", {30'd0, busy, mem_req}, 3);
        wr(12'h000, 32'h1);
        rd(12'h3FC, v); chk(v == 32'h1, "R7 error bit", v, 32'h1);
        chk(mem_addr == a0, "R7 address kept", mem_addr, a0);
        wr(12'h3F8, 32'h1);
        chk(irq == 1'b1, "R6 error irq", 32'(irq), 1);
        wr(12'h000, 32'h0);
        chk(!busy && !mem_req, "R8 stop", {30'd0, busy, mem_req}, 0);
        stall = 1'b0;
        repeat (DLY + 5) @(negedge clk);
        rd(12'h3FC, v); chk(v == 32'h1, "R7 no core run", v, 32'h1);
        wr(12'h3FC, 32'h3);
        chk(irq == 1'b0, "R6 error cleared", 32'(irq), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule